// File: doc/BRIEF.md
# Falling-Edge Timestamp Capture Bank

This block records when the first ten falling edges of a single-wire, pulse-coded input occur. A software or hardware agent pulses `arm`. That pulse clears a free-running time base and an edge counter in the same cycle, so every stored timestamp is measured from the same origin. After that, each synchronised falling edge advances the edge counter. When the count equals slot k's compare value (k+1), the current time base value is written into capture slot k. A whole frame is collected with no processor involvement.

The slots are kept in two hardware groups. The first group holds the six earliest edges and the second group holds the remaining four. After the ninth edge an early-ready flag rises. This lets a reader fetch the first nine timestamps while the final interval, which may be long, is still in progress. The tenth edge sets the frame-done flag and capture stops. Stored values can be read at any time through a registered read port indexed by slot number.

Top module: `edge_stamp_bank`

## Requirements
- R1: After reset, `armed`, `early_ready`, `frame_done`, `rd_slot_valid` and `rd_data` are all 0.
- R2: Only a falling edge of `sig_in` counts as an edge. The input passes through a two-flop synchroniser. A high-to-low change between two synchronised samples is one edge. A rising edge or a steady level never fills a slot.
- R3: The time base reads 0 in the cycle after `arm` is sampled and increments by one each cycle. Suppose `sig_in` is first sampled low at clock edge m. Then the edge is detected in the cycle after edge m+1, and the time base value of that cycle is written into the slot at edge m+2. Slot k (0..9) takes the (k+1)th detected edge after `arm`.
- R4: The time base is 24 bits wide. It free-runs from reset and is cleared only by `arm`.
- R5: `rd_idx` is sampled on a clock edge. At that edge `rd_data` and `rd_slot_valid` take the stored stamp and valid bit of that slot. An index of 10 to 15 returns 0 for both.
- R6: `early_ready` rises at the same edge as slot 8 becomes valid. It stays high until the next `arm`.
- R7: At the tenth capture, `frame_done` rises and `armed` falls. Later falling edges do not change any slot until the next `arm`.
- R8: An `arm` pulse, including one in the middle of a frame, clears all valid bits, `early_ready` and `frame_done`. It sets `armed`, and capture restarts at slot 0.
- R9: Falling edges that arrive before the first `arm` are ignored.
- R10: If `arm` is sampled in the same cycle that an edge is detected, the arm wins and that edge is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the time base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle pulse that starts a new frame |
| sig_in | input | 1 | Asynchronous pulse-coded input line |
| rd_idx | input | 4 | Slot index for the read port |
| rd_data | output | 24 | Timestamp of the addressed slot, one cycle after the index |
| rd_slot_valid | output | 1 | Valid bit of the addressed slot |
| armed | output | 1 | Capture in progress |
| early_ready | output | 1 | Nine slots filled |
| frame_done | output | 1 | Ten slots filled, capture stopped |

## Verification
The hardest case to reach from the ports is an `arm` pulse that lands in exactly the cycle in which a synchronised edge is detected. The detection cycle sits three flops behind the input pin. The stimulus therefore sweeps the arm pulse over a range of offsets after one falling edge, so that one offset hits the detection cycle and its neighbours fall just before and just after it. A mid-frame re-arm and edges that arrive after the frame is complete are also driven. A behavioural model predicts every slot, flag and read value on every cycle.

// File: rtl/esb_pkg.sv
package esb_pkg;
    localparam int unsigned TS_W_DEF     = 24;
    localparam int unsigned N_SLOTS_DEF  = 10;
    localparam int unsigned A_SLOTS_DEF  = 6;
    localparam int unsigned READY_AT_DEF = 9;
endpackage

// File: rtl/esb_edge_sync.sv
module esb_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1};
        else        st_q <= st_d;
    end

    assign fall_o = st_q.prev & ~st_q.s2;

    // R2
    single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/esb_timebase.sv
module esb_timebase #(
    parameter int unsigned W = esb_pkg::TS_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] tb_o
);
    logic [W-1:0] tb_d, tb_q;

    always_comb begin
        tb_d = clr ? '0 : tb_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign tb_o = tb_q;

    // R4
    tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> tb_q == W'($past(tb_q) + 1'b1));
    // R3
    tb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> tb_q == '0);
endmodule

// File: rtl/esb_cap_group.sv
module esb_cap_group #(
    parameter int unsigned TS_W  = esb_pkg::TS_W_DEF,
    parameter int unsigned NSLOT = 6,
    parameter int unsigned BASE  = 0,
    parameter int unsigned IDX_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       cap_en,
    input  logic [IDX_W-1:0]           cap_idx,
    input  logic [TS_W-1:0]            stamp,
    output logic [NSLOT-1:0][TS_W-1:0] slots_o,
    output logic [NSLOT-1:0]           valid_o
);
    typedef struct packed {
        logic [NSLOT-1:0][TS_W-1:0] slot;
        logic [NSLOT-1:0]           vld;
    } grp_t;

    grp_t g_d, g_q;
    logic [NSLOT-1:0] hit;

    for (genvar i = 0; i < NSLOT; i++) begin : g_hit
        assign hit[i] = cap_en && !g_q.vld[i] && (cap_idx == IDX_W'(BASE + i));
    end

    always_comb begin
        g_d = g_q;
        for (int i = 0; i < NSLOT; i++) begin
            if (clr) begin
                g_d.vld[i] = 1'b0;
            end else if (hit[i]) begin
                g_d.slot[i] = stamp;
                g_d.vld[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign slots_o = g_q.slot;
    assign valid_o = g_q.vld;

    for (genvar i = 0; i < NSLOT; i++) begin : g_chk
        // R7
        slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (g_q.vld[i] && !clr) |=> $stable(g_q.slot[i]));
    end
endmodule

// File: rtl/edge_stamp_bank.sv
module edge_stamp_bank #(
    parameter int unsigned TS_W     = esb_pkg::TS_W_DEF,
    parameter int unsigned N_SLOTS  = esb_pkg::N_SLOTS_DEF,
    parameter int unsigned A_SLOTS  = esb_pkg::A_SLOTS_DEF,
    parameter int unsigned READY_AT = esb_pkg::READY_AT_DEF,
    localparam int unsigned IDX_W   = $clog2(N_SLOTS),
    localparam int unsigned CNT_W   = $clog2(N_SLOTS + 1),
    localparam int unsigned B_SLOTS = N_SLOTS - A_SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             sig_in,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TS_W-1:0]  rd_data,
    output logic             rd_slot_valid,
    output logic             armed,
    output logic             early_ready,
    output logic             frame_done
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             early;
        logic             done;
        logic [TS_W-1:0]  rdat;
        logic             rvld;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                         fall;
    logic [TS_W-1:0]              tb;
    logic                         cap, cap_a, cap_b;
    logic [IDX_W-1:0]             cap_idx;
    logic [A_SLOTS-1:0][TS_W-1:0] slots_a;
    logic [B_SLOTS-1:0][TS_W-1:0] slots_b;
    logic [A_SLOTS-1:0]           vld_a;
    logic [B_SLOTS-1:0]           vld_b;
    logic [N_SLOTS-1:0][TS_W-1:0] slots_all;
    logic [N_SLOTS-1:0]           vld_all;

    esb_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (sig_in),
        .fall_o (fall)
    );

    esb_timebase #(.W(TS_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arm),
        .tb_o  (tb)
    );

    esb_cap_group #(.TS_W(TS_W), .NSLOT(A_SLOTS), .BASE(0), .IDX_W(IDX_W)) u_grp_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (arm),
        .cap_en  (cap_a),
        .cap_idx (cap_idx),
        .stamp   (tb),
        .slots_o (slots_a),
        .valid_o (vld_a)
    );

    esb_cap_group #(.TS_W(TS_W), .NSLOT(B_SLOTS), .BASE(A_SLOTS), .IDX_W(IDX_W)) u_grp_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (arm),
        .cap_en  (cap_b),
        .cap_idx (cap_idx),
        .stamp   (tb),
        .slots_o (slots_b),
        .valid_o (vld_b)
    );

    assign slots_all = {slots_b, slots_a};
    assign vld_all   = {vld_b, vld_a};

    assign cap     = !arm && c_q.active && fall;
    assign cap_idx = IDX_W'(c_q.cnt);
    assign cap_a   = cap && (c_q.cnt <  CNT_W'(A_SLOTS));
    assign cap_b   = cap && (c_q.cnt >= CNT_W'(A_SLOTS));

    always_comb begin
        c_d = c_q;
        if (arm) begin
            c_d.active = 1'b1;
            c_d.cnt    = '0;
            c_d.early  = 1'b0;
            c_d.done   = 1'b0;
        end else if (cap) begin
            c_d.cnt = c_q.cnt + 1'b1;
            if (c_q.cnt + 1'b1 == CNT_W'(READY_AT)) c_d.early = 1'b1;
            if (c_q.cnt + 1'b1 == CNT_W'(N_SLOTS)) begin
                c_d.done   = 1'b1;
                c_d.active = 1'b0;
            end
        end
        c_d.rdat = '0;
        c_d.rvld = 1'b0;
        for (int j = 0; j < N_SLOTS; j++) begin
            if (rd_idx == IDX_W'(j)) begin
                c_d.rdat = slots_all[j];
                c_d.rvld = vld_all[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_data       = c_q.rdat;
    assign rd_slot_valid = c_q.rvld;
    assign armed         = c_q.active;
    assign early_ready   = c_q.early;
    assign frame_done    = c_q.done;

    // R6
    early_has_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.early |-> vld_all[READY_AT-1]);
    // R7
    done_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |-> !c_q.active);
    // R7
    done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.done && !arm) |=> $stable(vld_all));
    // R8
    arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (c_q.cnt == '0 && c_q.active && !c_q.early && !c_q.done && vld_all == '0));
endmodule

// File: tb/edge_stamp_bank_tb_top.sv
module edge_stamp_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        sig_in = 1'b1;
    logic [3:0]  rd_idx = '0;
    logic [3:0]  man_idx = '0;
    bit          auto_rd = 1'b1;
    logic [23:0] rd_data;
    logic        rd_slot_valid, armed, early_ready, frame_done;

    int vectors = 0;
    int errors  = 0;
    string phase = "R1";
    bit done_flag = 0;

    always #4 clk = ~clk;

    edge_stamp_bank dut_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .sig_in(sig_in), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_slot_valid(rd_slot_valid), .armed(armed),
        .early_ready(early_ready), .frame_done(frame_done)
    );

    // behavioural reference model
    bit          sq[$];
    int          m_tb, m_cnt;
    bit          m_act, m_er, m_fd;
    int          m_slot[10];
    bit          m_val[10];
    int          e_rd;
    bit          e_rv;

    always @(posedge clk) begin
        if (!rst_n) begin
            sq = {1'b1, 1'b1, 1'b1, 1'b1};
            m_tb = 0; m_cnt = 0; m_act = 0; m_er = 0; m_fd = 0;
            e_rd = 0; e_rv = 0;
            for (int i = 0; i < 10; i++) begin m_slot[i] = 0; m_val[i] = 0; end
        end else begin
            bit f;
            if (rd_idx < 10) begin e_rd = m_slot[rd_idx]; e_rv = m_val[rd_idx]; end
            else begin e_rd = 0; e_rv = 0; end
            sq.push_back(sig_in);
            if (sq.size() > 4) void'(sq.pop_front());
            f = (sq[0] == 1'b1) && (sq[1] == 1'b0);
            if (arm) begin
                m_tb = 0; m_cnt = 0; m_act = 1; m_er = 0; m_fd = 0;
                for (int i = 0; i < 10; i++) m_val[i] = 0;
            end else begin
                if (m_act && f) begin
                    m_slot[m_cnt] = m_tb; m_val[m_cnt] = 1; m_cnt++;
                    if (m_cnt == 9)  m_er = 1;
                    if (m_cnt == 10) begin m_fd = 1; m_act = 0; end
                end
                m_tb = (m_tb + 1) & 24'hFFFFFF;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (phase %s): actual %0h expected %0h", tag, phase, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk(rd_data == 24'(e_rd), "R3/R5 rd_data", int'(rd_data), e_rd);
            chk(rd_slot_valid == e_rv, "R5 rd_slot_valid", int'(rd_slot_valid), int'(e_rv));
            chk(early_ready == m_er, "R6 early_ready", int'(early_ready), int'(m_er));
            chk(frame_done == m_fd, "R7 frame_done", int'(frame_done), int'(m_fd));
            chk(armed == m_act, "R8 armed", int'(armed), int'(m_act));
        end
        rd_idx <= auto_rd ? rd_idx + 4'd1 : man_idx;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm_pulse();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic pulse(input int lo, input int hi);
        @(negedge clk); sig_in = 1'b0;
        cyc(lo);
        sig_in = 1'b1;
        cyc(hi);
    endtask

    task automatic read_slot(input int k, output logic [23:0] d, output logic v);
        man_idx = 4'(k); auto_rd = 0;
        cyc(3);
        d = rd_data; v = rd_slot_valid;
        auto_rd = 1;
    endtask

    task automatic frame(input int seed);
        pulse(5, 51);
        for (int n = 0; n < 8; n++) pulse(5, 7 + ((n * 5 + seed) % 16));
        pulse(5, 20);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        done_flag = 1;
        summary();
    end

    initial begin
        logic [23:0] d;
        logic v;
        cyc(5);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(armed == 0 && early_ready == 0 && frame_done == 0, "R1 flags", int'({armed, early_ready, frame_done}), 0);
        chk(rd_slot_valid == 0 && rd_data == 0, "R1 read port", int'(rd_data), 0);

        // R9: edges before any arm
        phase = "R9";
        repeat (3) pulse(4, 6);
        read_slot(0, d, v);
        chk(v == 0, "R9 slot0 valid", int'(v), 0);

        // R2: line low before arm, only a rising edge afterwards
        phase = "R2";
        @(negedge clk); sig_in = 1'b0;
        cyc(6);
        arm_pulse();
        cyc(3); sig_in = 1'b1; cyc(10);
        read_slot(0, d, v);
        chk(v == 0, "R2 slot0 after rising edge only", int'(v), 0);

        // R3/R4/R6/R7: full frame
        phase = "R3";
        arm_pulse();
        pulse(5, 51);
        for (int n = 0; n < 7; n++) pulse(5, 9 + 2 * n);
        chk(early_ready == 0, "R6 before ninth edge", int'(early_ready), 0);
        pulse(5, 30);
        chk(early_ready == 1 && frame_done == 0, "R6 after ninth edge", int'({early_ready, frame_done}), 2);
        pulse(5, 20);
        chk(frame_done == 1 && armed == 0, "R7 after tenth edge", int'({frame_done, armed}), 2);
        for (int k = 0; k < 10; k++) begin
            read_slot(k, d, v);
            chk(v == 1 && d == 24'(m_slot[k]), "R3 slot stamp", int'(d), m_slot[k]);
        end
        read_slot(12, d, v);
        chk(v == 0 && d == 0, "R5 out-of-range index", int'(d), 0);
        phase = "R7";
        repeat (4) pulse(5, 9);
        read_slot(9, d, v);
        chk(d == 24'(m_slot[9]), "R7 slot9 frozen", int'(d), m_slot[9]);

        // R8: re-arm mid-frame
        phase = "R8";
        arm_pulse();
        repeat (4) pulse(5, 12);
        arm_pulse();
        read_slot(0, d, v);
        chk(v == 0 && early_ready == 0, "R8 cleared by re-arm", int'(v), 0);
        frame(3);
        read_slot(0, d, v);
        chk(v == 1 && d == 24'(m_slot[0]), "R8 restart at slot 0", int'(d), m_slot[0]);

        // R10: arm swept across the detection cycle of an edge
        phase = "R10";
        for (int off = 0; off < 6; off++) begin
            arm_pulse();
            cyc(4);
            @(negedge clk); sig_in = 1'b0;
            cyc(off);
            arm = 1'b1; @(negedge clk); arm = 1'b0;
            cyc(6); sig_in = 1'b1; cyc(8);
            frame(off);
            cyc(5);
        end

        // glitch-width pulses in a frame
        phase = "R2 narrow";
        arm_pulse();
        repeat (10) pulse(1, 4);
        cyc(10);

        done_flag = 1;
        summary();
    end
endmodule